// File: doc/BRIEF.md
# Bus Transaction Phase Monitor

This block watches a 32-bit parallel multiplexed address/data bus with active-low framing and handshake lines. It runs in the bus clock domain and looks at every line only on the rising edge. It follows each transaction through a fixed set of states:

- idle
- the single address cycle
- one or more data phases, which may contain wait cycles from either side
- a final data phase
- a turnaround back to idle

In the address cycle it captures the address and the 4-bit command. It names the command type and decides whether this agent, acting as target, responds to it. It then holds that decision for the rest of the transaction.

The machine has five states:

| State | Code | Entered |
|---|---|---|
| `PH_IDLE` | 0 | Out of reset |
| `PH_ADDR` | 1 | From idle when the frame line is sampled low |
| `PH_DATA` | 2 | From address or data when the frame line is still low |
| `PH_LAST` | 3 | When the frame line is high, the initiator is ready, and no transfer completed |
| `PH_TURN` | 4 | From address, data or last when a transfer completes with the frame line high |

`PH_TURN` falls back to `PH_IDLE` once both the frame and the initiator-ready lines are high. Every output is registered. Each output reflects the bus as sampled at the most recent rising edge.

Top module: `pcimon_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `phase`=0, `cmd_type`=0, `accept`=0 and `xfer_strobe`=0.
- R2: In idle, an edge that samples `frame_n`=0 sets `phase`=1 (address) and captures `ad` into `addr_q`. The next edge leaves address for data (2), last (3) or turnaround (4), and never for idle.
- R3: `xfer_strobe` is high for exactly one cycle after each edge in address, data or last at which `irdy_n`=0 and `trdy_n`=0. It stays low after any edge where either line is high, so wait cycles give no strobe.
- R4: An edge that samples `frame_n`=1 and `irdy_n`=0 marks the final data phase. Without a transfer, `phase` goes to 3. With a transfer, `phase` goes to 4. After 4, `phase` returns to 0 at the first edge that samples `frame_n`=1 and `irdy_n`=1.
- R5: `cmd_type` decodes `cbe` in the address cycle as follows:

  | `cbe` | `cmd_type` | Meaning |
  |---|---|---|
  | 0111 | 1 | memory write |
  | 1010 | 2 | configuration read |
  | 1011 | 3 | configuration write |
  | 1100 | 4 | memory read multiple |
  | 1101 | 5 | dual address cycle |
  | 1110 | 6 | memory read line |
  | 1111 | 7 | memory write and invalidate |
  | 1000, 1001 | 8 | reserved |
  | any other value | 9 | unsupported |

  `cmd_type` is 0 whenever `phase` is 0.
- R6: Commands of type 1, 4, 6 and 7 set `accept`=1.
- R7: Types 2 and 3 set `accept`=1 only if `agent_mode`=1 and `idsel`=1 are both sampled in the address cycle. Otherwise `accept`=0.
- R8: The dual address cycle (type 5) gives `accept`=0.
- R9: The reserved codes 1000 and 1001 give `accept`=0.
- R10: Unsupported codes (0000 through 0110) give `accept`=0.
- R11: `cmd_type`, `accept` and `addr_q` hold their address-cycle values until `phase` returns to 0. Changes on `cbe`, `idsel` or `agent_mode` during data phases have no effect on them. On return to idle, `cmd_type` and `accept` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame line, driven by the initiator |
| irdy_n | input | 1 | Active-low initiator-ready line |
| trdy_n | input | 1 | Active-low target-ready line |
| idsel | input | 1 | Configuration select, sampled in the address cycle |
| agent_mode | input | 1 | 1 selects agent mode, 0 selects host mode |
| cbe | input | 4 | Command / byte-enable lines |
| ad | input | ADDR_W | Multiplexed address/data lines |
| phase | output | 3 | Current state code (0..4, listed above) |
| cmd_type | output | 4 | Decoded command type (R5) |
| accept | output | 1 | 1 when this agent responds to the current transaction |
| xfer_strobe | output | 1 | One-cycle pulse per completed data transfer |
| addr_q | output | ADDR_W | Address captured in the address cycle |

## Verification
Every result lands one cycle after the edge that sampled its stimulus:

- `phase`, `cmd_type`, `accept` and `addr_q` change right after the address edge.
- `xfer_strobe` rises right after the handshake edge.

The bench drives the bus lines on the falling clock edge and waits for the next rising edge. It then checks 2 ns later, before the next drive. Each expected value is therefore matched to the single edge that produced it.

The hold checks change `cbe`, `idsel` and `agent_mode` during data phases, then read the held outputs in the cycles that follow.

// File: rtl/pcimon_pkg.sv
package pcimon_pkg;

    localparam int CBE_W   = 4;
    localparam int PHASE_W = 3;
    localparam int KIND_W  = 4;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_DATA = 3'd2,
        PH_LAST = 3'd3,
        PH_TURN = 3'd4
    } phase_e;

    typedef enum logic [KIND_W-1:0] {
        K_NONE     = 4'd0,
        K_MEM_WR   = 4'd1,
        K_CFG_RD   = 4'd2,
        K_CFG_WR   = 4'd3,
        K_MEM_RDM  = 4'd4,
        K_DUAL     = 4'd5,
        K_MEM_RDL  = 4'd6,
        K_MEM_WRI  = 4'd7,
        K_RESV     = 4'd8,
        K_OTHER    = 4'd9
    } kind_e;

endpackage

// File: rtl/pcimon_cmd_decode.sv
module pcimon_cmd_decode
    import pcimon_pkg::*;
(
    input  logic [CBE_W-1:0] cbe,
    input  logic             agent_mode,
    input  logic             idsel,
    output kind_e            kind,
    output logic             ok
);

    // Command code to type (R5)
    always_comb begin
        unique case (cbe)
            4'b0111:          kind = K_MEM_WR;
            4'b1000, 4'b1001: kind = K_RESV;
            4'b1010:          kind = K_CFG_RD;
            4'b1011:          kind = K_CFG_WR;
            4'b1100:          kind = K_MEM_RDM;
            4'b1101:          kind = K_DUAL;
            4'b1110:          kind = K_MEM_RDL;
            4'b1111:          kind = K_MEM_WRI;
            default:          kind = K_OTHER;
        endcase
    end

    // Target support table (R6..R10)
    always_comb begin
        unique case (kind)
            K_MEM_WR, K_MEM_RDM, K_MEM_RDL, K_MEM_WRI: ok = 1'b1;
            K_CFG_RD, K_CFG_WR:                        ok = agent_mode & idsel;
            default:                                   ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcimon_phase_fsm.sv
module pcimon_phase_fsm
    import pcimon_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_n,
    input  logic   irdy_n,
    input  logic   trdy_n,
    output phase_e state,
    output logic   capture,
    output logic   to_idle,
    output logic   xfer_strobe
);

    phase_e next;
    logic   hs;
    logic   in_data;

    assign hs      = ~irdy_n & ~trdy_n;
    assign in_data = (state == PH_ADDR) | (state == PH_DATA) | (state == PH_LAST);
    assign capture = (state == PH_IDLE) & ~frame_n;
    assign to_idle = (state != PH_IDLE) & (next == PH_IDLE);

    always_comb begin
        next = state;
        unique case (state)
            PH_IDLE: if (!frame_n) next = PH_ADDR;
            PH_ADDR, PH_DATA: begin
                if (hs && frame_n)           next = PH_TURN;
                else if (frame_n && !irdy_n) next = PH_LAST;
                else                         next = PH_DATA;
            end
            PH_LAST: if (hs) next = PH_TURN;
            PH_TURN: if (frame_n && irdy_n) next = PH_IDLE;
            default: next = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= next;
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_strobe <= 1'b0;
        else        xfer_strobe <= in_data & hs;
    end

    assert_strobe_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strobe |-> $past(~irdy_n & ~trdy_n));

    assert_addr_not_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_ADDR) |=> (state == PH_DATA || state == PH_LAST || state == PH_TURN));

    assert_last_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LAST && !irdy_n && !trdy_n) |=> (state == PH_TURN));

endmodule

// File: rtl/pcimon_txn_hold.sv
module pcimon_txn_hold
    import pcimon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              to_idle,
    input  kind_e             kind_in,
    input  logic              ok_in,
    input  logic [ADDR_W-1:0] ad,
    output kind_e             kind_q,
    output logic              accept_q,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= K_NONE;
            accept_q <= 1'b0;
            addr_q   <= '0;
        end else if (capture) begin
            kind_q   <= kind_in;
            accept_q <= ok_in;
            addr_q   <= ad;
        end else if (to_idle) begin
            kind_q   <= K_NONE;
            accept_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pcimon_top.sv
module pcimon_top
    import pcimon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              idsel,
    input  logic              agent_mode,
    input  logic [3:0]        cbe,
    input  logic [ADDR_W-1:0] ad,
    output logic [2:0]        phase,
    output logic [3:0]        cmd_type,
    output logic              accept,
    output logic              xfer_strobe,
    output logic [ADDR_W-1:0] addr_q
);

    phase_e st;
    kind_e  kind_d, kind_q;
    logic   ok_d, capture, to_idle;

    pcimon_cmd_decode u_dec (
        .cbe        (cbe),
        .agent_mode (agent_mode),
        .idsel      (idsel),
        .kind       (kind_d),
        .ok         (ok_d)
    );

    pcimon_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n     (frame_n),
        .irdy_n      (irdy_n),
        .trdy_n      (trdy_n),
        .state       (st),
        .capture     (capture),
        .to_idle     (to_idle),
        .xfer_strobe (xfer_strobe)
    );

    pcimon_txn_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .to_idle  (to_idle),
        .kind_in  (kind_d),
        .ok_in    (ok_d),
        .ad       (ad),
        .kind_q   (kind_q),
        .accept_q (accept),
        .addr_q   (addr_q)
    );

    assign phase    = st;
    assign cmd_type = kind_q;

    assert_cfg_needs_agent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && cbe[3:1] == 3'b101 && !(agent_mode && idsel)) |=> !accept);

    assert_dual_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && cbe == 4'b1101) |=> !accept);

    assert_resv_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && cbe[3:1] == 3'b100) |=> !accept);

    assert_low_codes_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && cbe[3] == 1'b0 && cbe != 4'b0111) |=> !accept);

    assert_txn_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd0 && $past(phase) != 3'd0) |-> ($stable(cmd_type) && $stable(accept)));

    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0) |-> (cmd_type == 4'd0 && !accept));

endmodule

// File: tb/pcimon_top_tb_top.sv
module pcimon_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic        idsel = 1'b0, agent_mode = 1'b0;
    logic [3:0]  cbe = 4'd0;
    logic [31:0] ad = 32'd0;
    logic [2:0]  phase;
    logic [3:0]  cmd_type;
    logic        accept, xfer_strobe;
    logic [31:0] addr_q;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pcimon_top dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .idsel(idsel), .agent_mode(agent_mode), .cbe(cbe), .ad(ad),
        .phase(phase), .cmd_type(cmd_type), .accept(accept),
        .xfer_strobe(xfer_strobe), .addr_q(addr_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 2 ns after the next rising edge
    task automatic cyc(input logic f, input logic i, input logic t);
        @(negedge clk);
        frame_n = f; irdy_n = i; trdy_n = t;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [3:0] exp_kind(input logic [3:0] c);
        case (c)
            4'b0111: return 4'd1;
            4'b1010: return 4'd2;
            4'b1011: return 4'd3;
            4'b1100: return 4'd4;
            4'b1101: return 4'd5;
            4'b1110: return 4'd6;
            4'b1111: return 4'd7;
            4'b1000, 4'b1001: return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

    function automatic logic exp_acc(input logic [3:0] c, input logic m, input logic s);
        case (c)
            4'b0111, 4'b1100, 4'b1110, 4'b1111: return 1'b1;
            4'b1010, 4'b1011: return m & s;
            default: return 1'b0;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 phase", phase, 0);
        chk("R1 cmd_type", cmd_type, 0);
        chk("R1 accept", accept, 0);
        chk("R1 strobe", xfer_strobe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, 1);
        chk("R1 phase after release", phase, 0);
        chk("R1 strobe after release", xfer_strobe, 0);
    endtask

    // Single data phase transaction for one command code
    task automatic t_single(input logic [3:0] c, input logic m, input logic s, input logic [31:0] a);
        logic [3:0] ek;
        logic       ea;
        ek = exp_kind(c);
        ea = exp_acc(c, m, s);
        @(negedge clk);
        cbe = c; agent_mode = m; idsel = s; ad = a;
        frame_n = 0; irdy_n = 1; trdy_n = 1;
        @(posedge clk);
        #2;
        chk("R2 phase addr", phase, 1);
        chk("R2 addr_q", addr_q, a);
        chk("R5 cmd_type", cmd_type, ek);
        if (c[3:1] == 3'b101)               chk("R7 cfg accept", accept, ea);
        else if (c == 4'b1101)              chk("R8 dual accept", accept, ea);
        else if (c[3:1] == 3'b100)          chk("R9 reserved accept", accept, ea);
        else if (c[3] == 1'b0 && c != 4'b0111) chk("R10 unsupported accept", accept, ea);
        else                                chk("R6 memory accept", accept, ea);
        // data phase, last, completes; disturb cbe/idsel/mode
        @(negedge clk);
        cbe = ~c; idsel = ~s; agent_mode = ~m; ad = ~a;
        frame_n = 1; irdy_n = 0; trdy_n = 0;
        @(posedge clk);
        #2;
        chk("R4 phase turn", phase, 4);
        chk("R3 strobe", xfer_strobe, 1);
        chk("R11 cmd hold", cmd_type, ek);
        chk("R11 accept hold", accept, ea);
        chk("R11 addr hold", addr_q, a);
        cyc(1, 1, 1);
        chk("R4 back idle", phase, 0);
        chk("R3 strobe one cycle", xfer_strobe, 0);
        chk("R5 idle cmd_type", cmd_type, 0);
        chk("R11 accept cleared", accept, 0);
    endtask

    // Multi-phase burst with wait states from both sides
    task automatic t_burst();
        @(negedge clk);
        cbe = 4'b0111; agent_mode = 0; idsel = 0; ad = 32'hA5A5_0040;
        frame_n = 0; irdy_n = 1; trdy_n = 1;
        @(posedge clk);
        #2;
        chk("R2 burst addr", phase, 1);
        chk("R6 burst accept", accept, 1);
        cyc(0, 0, 1);
        chk("R2 to data", phase, 2);
        chk("R3 target wait no strobe", xfer_strobe, 0);
        cyc(0, 1, 0);
        chk("R3 initiator wait no strobe", xfer_strobe, 0);
        cyc(0, 0, 0);
        chk("R3 burst strobe", xfer_strobe, 1);
        chk("R3 still data", phase, 2);
        cyc(0, 0, 0);
        chk("R3 back-to-back strobe", xfer_strobe, 1);
        cyc(1, 0, 1);
        chk("R4 last phase", phase, 3);
        chk("R3 last wait no strobe", xfer_strobe, 0);
        chk("R11 cmd held", cmd_type, 1);
        cyc(1, 0, 0);
        chk("R4 turn", phase, 4);
        chk("R3 final strobe", xfer_strobe, 1);
        cyc(1, 0, 1);
        chk("R4 stays turn while irdy low", phase, 4);
        cyc(1, 1, 1);
        chk("R4 idle", phase, 0);
        chk("R11 accept cleared", accept, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        for (int k = 0; k < 16; k++) t_single(k[3:0], 1'b1, 1'b1, 32'h1000_0000 + k);
        t_single(4'b1010, 1'b0, 1'b1, 32'h0000_0100); // R7 host mode
        t_single(4'b1011, 1'b1, 1'b0, 32'h0000_0200); // R7 idsel low
        t_single(4'b1011, 1'b0, 1'b0, 32'h0000_0300); // R7 both low
        t_burst();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule